// File: doc/BRIEF.md
# Double-Buffered Converter Data Latch

This block is the digital front end of an 8-bit converter whose input word passes through two cascaded holding stages before it reaches the analog section. The first stage is the input holder. It opens when its active-high enable is set and both the active-low select and the first active-low write strobe are low. The second stage is the converter holder. It opens when the second write strobe and the transfer strobe, both active low, are low at the same time, and it then takes the first stage's value. The output word is the converter holder's contents.

The same structure covers three ways of use. In double-buffered use, new data is placed in the input holder and later moved to the output, so several converters can change together. In single-buffered use, the converter holder is left open and the first write strobe alone updates the output. In flow-through use, every control is left active and the output tracks the data inputs. Each level-sensitive stage is modelled as a register sampled on a fast system clock, and every control is taken as synchronous to that clock. A stage that is open reloads on every clock edge. When its strobe rises, the stage keeps the data of the last clock in which it was open.

The strobes act as the handshake at the data edge, so there is no valid/ready pair and no back-pressure. A write is accepted on every clock in which the input holder is open.

Top module: `dual_stage_dac_latch`

## Requirements
- R1: A synchronous active-high reset clears both stages, so `dac_word` reads 0x00 and `flow_thru` reads 0 in the cycle after a reset edge.
- R2: The input stage loads `data_in` on a clock edge only when `latch_en`=1, `sel_n`=0 and `wr_a_n`=0 are all true. In every other cycle it keeps its value.
- R3: When `wr_b_n`=1 or `xfer_n`=1 at a clock edge, `dac_word` keeps its value after that edge, whatever the data and the input-stage controls do.
- R4: When `wr_b_n`=0 and `xfer_n`=0 at a clock edge, `dac_word` takes the value the input stage holds after that same edge. If the input stage also loads in that cycle, this is the fresh `data_in` and not the older stored value.
- R5: Single-buffered use: with `sel_n`, `wr_b_n` and `xfer_n` low and `latch_en` high, `dac_word` equals the `data_in` of the previous clock while `wr_a_n` is low, and keeps its value while `wr_a_n` is high.
- R6: Flow-through use: with all four active-low controls low and `latch_en` high, `dac_word` equals the `data_in` sampled at the previous clock edge, on every cycle.
- R7: After a write strobe rises, the stage it controls keeps the data of the last clock edge at which that strobe was low and qualified.
- R8: `flow_thru` is 1 in the cycle after an edge at which both stages were open, and 0 after any other edge.
- R9: A low `wr_a_n` has no effect on the input stage when `latch_en`=0 or `sel_n`=1. A later transfer shows the older value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both stages |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data word from the bus |
| latch_en | input | 1 | Input stage enable, active high |
| sel_n | input | 1 | Select, active low, qualifies the first write |
| wr_a_n | input | 1 | First write strobe, active low, opens the input stage |
| wr_b_n | input | 1 | Second write strobe, active low, part of the transfer |
| xfer_n | input | 1 | Transfer strobe, active low, part of the transfer |
| dac_word | output | 8 | Word presented to the analog stage |
| flow_thru | output | 1 | High when both stages were transparent in the last cycle |

## Verification
A load into the input stage and a transfer into the converter stage can fall in the same clock. The converter must then take the incoming data word and not the stale contents of the input stage. The bench provokes this by dropping `wr_a_n`, `wr_b_n` and `xfer_n` together for a single cycle, with a data value different from the one already stored. It then checks that `dac_word` shows the new value one cycle later and that `flow_thru` is raised for exactly that cycle.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  // Which stages are transparent in a given cycle.
  typedef enum logic [1:0] {
    PATH_HOLD  = 2'b00,
    PATH_INPUT = 2'b01,
    PATH_XFER  = 2'b10,
    PATH_FLOW  = 2'b11
  } path_mode_e;

  localparam int unsigned NUM_STAGES = 2;
  localparam int unsigned STG_IN     = 0;
  localparam int unsigned STG_CONV   = 1;

  function automatic path_mode_e mode_of(input logic [NUM_STAGES-1:0] open_v);
    path_mode_e m;
    unique case (open_v)
      2'b00:   m = PATH_HOLD;
      2'b01:   m = PATH_INPUT;
      2'b10:   m = PATH_XFER;
      default: m = PATH_FLOW;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dsl_qualify.sv
module dsl_qualify
  import dsl_pkg::*;
(
  input  logic                  latch_en,
  input  logic                  sel_n,
  input  logic                  wr_a_n,
  input  logic                  wr_b_n,
  input  logic                  xfer_n,
  output logic [NUM_STAGES-1:0] open_o,
  output path_mode_e            mode_o
);

  logic in_gate;
  logic conv_gate;

  // Input stage: enable high, select low and first strobe low.
  assign in_gate   = latch_en & ~sel_n & ~wr_a_n;
  // Converter stage: second strobe and transfer both low.
  assign conv_gate = ~wr_b_n & ~xfer_n;

  always_comb begin
    open_o           = '0;
    open_o[STG_IN]   = in_gate;
    open_o[STG_CONV] = conv_gate;
  end

  assign mode_o = mode_of(open_o);

endmodule

// File: rtl/dsl_stage.sv
module dsl_stage #(
  parameter int unsigned        WIDTH   = 8,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] nxt_o
);

  logic [WIDTH-1:0] hold_q;

  // Value the stage will hold after this edge; open stages pass through.
  assign nxt_o = open_i ? d_i : hold_q;
  assign q_o   = hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= RST_VAL;
    else     hold_q <= nxt_o;
  end

endmodule

// File: rtl/dual_stage_dac_latch.sv
module dual_stage_dac_latch
  import dsl_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_in,
  input  logic             latch_en,
  input  logic             sel_n,
  input  logic             wr_a_n,
  input  logic             wr_b_n,
  input  logic             xfer_n,
  output logic [WIDTH-1:0] dac_word,
  output logic             flow_thru
);

  localparam logic [WIDTH-1:0] ZERO_WORD = '0;

  logic [NUM_STAGES-1:0] stage_open;
  path_mode_e            mode_now;
  path_mode_e            mode_q;

  logic [WIDTH-1:0] stage_in  [NUM_STAGES];
  logic [WIDTH-1:0] stage_q   [NUM_STAGES];
  logic [WIDTH-1:0] stage_nxt [NUM_STAGES];

  dsl_qualify u_qual (
    .latch_en (latch_en),
    .sel_n    (sel_n),
    .wr_a_n   (wr_a_n),
    .wr_b_n   (wr_b_n),
    .xfer_n   (xfer_n),
    .open_o   (stage_open),
    .mode_o   (mode_now)
  );

  // Cascade: each stage is fed the next-state value of the one before,
  // so transparency chains through within a single clock.
  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_head
      assign stage_in[gi] = data_in;
    end else begin : g_tail
      assign stage_in[gi] = stage_nxt[gi-1];
    end

    dsl_stage #(
      .WIDTH   (WIDTH),
      .RST_VAL (ZERO_WORD)
    ) u_stage (
      .clk    (clk),
      .rst    (rst),
      .open_i (stage_open[gi]),
      .d_i    (stage_in[gi]),
      .q_o    (stage_q[gi]),
      .nxt_o  (stage_nxt[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= PATH_HOLD;
    else     mode_q <= mode_now;
  end

  assign dac_word  = stage_q[NUM_STAGES-1];
  assign flow_thru = (mode_q == PATH_FLOW);

endmodule

// File: rtl/dsl_checker.sv
module dsl_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] data_in,
  input logic             latch_en,
  input logic             sel_n,
  input logic             wr_a_n,
  input logic             wr_b_n,
  input logic             xfer_n,
  input logic [WIDTH-1:0] in_word,
  input logic [WIDTH-1:0] dac_word,
  input logic             flow_thru
);

  logic in_ok;
  logic cv_ok;
  assign in_ok = latch_en && !sel_n && !wr_a_n;
  assign cv_ok = !wr_b_n && !xfer_n;

  // R1: reset clears the output and the flag
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dac_word == '0) && !flow_thru);

  // R2 / R9: an unqualified cycle leaves the input stage alone
  p_input_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !in_ok |=> $stable(in_word));

  // R3: a high second strobe or transfer holds the output
  p_output_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cv_ok |=> $stable(dac_word));

  // R4: a transfer alone copies the stored input word
  p_xfer_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (cv_ok && !in_ok) |=> (dac_word == $past(in_word)));

  // R6: with both stages open the output follows the data
  p_flow_track_r6: assert property (@(posedge clk) disable iff (rst)
    (cv_ok && in_ok) |=> (dac_word == $past(data_in)));

  // R8: flag reflects both stages open in the previous cycle
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    (cv_ok && in_ok) |=> flow_thru);
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (rst)
    !(cv_ok && in_ok) |=> !flow_thru);

endmodule

bind dual_stage_dac_latch dsl_checker #(.WIDTH(WIDTH)) u_dsl_checker (
  .clk       (clk),
  .rst       (rst),
  .data_in   (data_in),
  .latch_en  (latch_en),
  .sel_n     (sel_n),
  .wr_a_n    (wr_a_n),
  .wr_b_n    (wr_b_n),
  .xfer_n    (xfer_n),
  .in_word   (stage_q[0]),
  .dac_word  (dac_word),
  .flow_thru (flow_thru)
);

// File: tb/dual_stage_dac_latch_bench.sv
module dual_stage_dac_latch_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic       latch_en = 1'b0;
  logic       sel_n = 1'b1;
  logic       wr_a_n = 1'b1;
  logic       wr_b_n = 1'b1;
  logic       xfer_n = 1'b1;
  logic [7:0] dac_word;
  logic       flow_thru;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_stage_dac_latch u_dual_stage_dac_latch (
    .clk(clk), .rst(rst), .data_in(data_in), .latch_en(latch_en),
    .sel_n(sel_n), .wr_a_n(wr_a_n), .wr_b_n(wr_b_n), .xfer_n(xfer_n),
    .dac_word(dac_word), .flow_thru(flow_thru)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_word(input string req, input logic [7:0] exp);
    n_checks++;
    if (dac_word !== exp) begin
      n_errors++;
      $display("FAIL %s: dac_word=%02h expected %02h", req, dac_word, exp);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp);
    n_checks++;
    if (flow_thru !== exp) begin
      n_errors++;
      $display("FAIL %s: flow_thru=%0b expected %0b", req, flow_thru, exp);
    end
  endtask

  task automatic close_all();
    latch_en = 1'b0; sel_n = 1'b1; wr_a_n = 1'b1; wr_b_n = 1'b1; xfer_n = 1'b1;
  endtask

  task automatic t_reset();
    close_all(); rst = 1'b1; data_in = 8'h5A;
    step(); step();
    chk_word("R1", 8'h00);
    chk_flag("R1", 1'b0);
    rst = 1'b0;
    step();
    chk_word("R1", 8'h00);
  endtask

  task automatic t_double_buffer();
    latch_en = 1'b1; sel_n = 1'b0; wr_a_n = 1'b0; data_in = 8'hA5;
    step();
    data_in = 8'h3C;
    step();
    wr_a_n = 1'b1; data_in = 8'hFF;
    step();
    chk_word("R3", 8'h00);
    wr_b_n = 1'b0;                     // R3: second strobe alone is not enough
    step();
    chk_word("R3", 8'h00);
    wr_b_n = 1'b1; xfer_n = 1'b0;       // R3: transfer alone is not enough
    step();
    chk_word("R3", 8'h00);
    wr_b_n = 1'b0;
    step();
    chk_word("R7", 8'h3C);              // R4/R7: last qualified data
    chk_flag("R8", 1'b0);
    close_all();
    step();
  endtask

  task automatic t_blocked();
    latch_en = 1'b0; sel_n = 1'b0; wr_a_n = 1'b0; data_in = 8'h11;
    step();
    latch_en = 1'b1; sel_n = 1'b1; data_in = 8'h22;
    step();
    close_all();
    wr_b_n = 1'b0; xfer_n = 1'b0;
    step();
    chk_word("R9", 8'h3C);
    chk_word("R2", 8'h3C);
    close_all();
    step();
  endtask

  task automatic t_same_cycle();
    latch_en = 1'b1; sel_n = 1'b0; wr_a_n = 1'b0;
    wr_b_n = 1'b0; xfer_n = 1'b0; data_in = 8'h77;
    step();
    chk_word("R4", 8'h77);
    chk_flag("R8", 1'b1);
    close_all(); data_in = 8'h00;
    step();
    chk_word("R3", 8'h77);
    chk_flag("R8", 1'b0);
  endtask

  task automatic t_single();
    latch_en = 1'b1; sel_n = 1'b0; wr_b_n = 1'b0; xfer_n = 1'b0;
    wr_a_n = 1'b1; data_in = 8'h10;
    step();
    chk_word("R5", 8'h77);
    wr_a_n = 1'b0; data_in = 8'h20;
    step();
    chk_word("R5", 8'h20);
    data_in = 8'h21;
    step();
    chk_word("R5", 8'h21);
    wr_a_n = 1'b1; data_in = 8'h99;
    step();
    chk_word("R7", 8'h21);
    data_in = 8'h42;
    step();
    chk_word("R5", 8'h21);
    close_all();
    step();
  endtask

  task automatic t_flow();
    latch_en = 1'b1; sel_n = 1'b0; wr_a_n = 1'b0; wr_b_n = 1'b0; xfer_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(i * 37 + 5);
      data_in = v;
      step();
      chk_word("R6", v);
      chk_flag("R8", 1'b1);
    end
  endtask

  task automatic t_reset_mid();
    data_in = 8'hEE; rst = 1'b1;
    step();
    chk_word("R1", 8'h00);
    chk_flag("R1", 1'b0);
    close_all(); rst = 1'b0;
    step();
  endtask

  initial begin
    t_reset();
    t_double_buffer();
    t_blocked();
    t_same_cycle();
    t_single();
    t_flow();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: done=0 expected 1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule